// File: doc/BRIEF.md
# Board-Wiring Register Write Decoder

This block sits between the CPU bus and the register files of a cartridge bank controller. On each CPU write it turns the 16-bit address into a register select that is the same for every board wiring. The select has a 4-bit group taken from the top address nibble and a 2-bit sub-index. Different boards route different pairs of low address lines into the controller, sometimes with the two lines swapped. A static variant code tells the decoder which two lines form the sub-index and which of them is the low bit. The rest of the chip can then use one register map for every board.

Every output is registered, so the select appears one clock after the write strobe. Each output is a single-cycle pulse. The block gives the select in two forms: an encoded group and sub-index, and a one-hot vector with one bit for each register in the $8000-$FFFF window. The four registers of the $F group also get their own write strobes, for the timer interrupt logic.

Top module: `vdec_top`

## Requirements
- R1: A write whose address has A15 = 0 produces no select. On the following cycle `sel_valid`, `sel_onehot` and `irq_we` are all zero.
- R2: With `wr_stb` high, A15 = 1 and a supported variant, `sel_valid` is 1 on the cycle after the strobe. With `wr_stb` low, `sel_valid` is 0 on the next cycle.
- R3: `sel_group` equals address bits A15-A12 of the write that caused it.
- R4: Variant 0 takes sub bit 0 from A1 and sub bit 1 from A2 (offsets 0, 2, 4, 6). Variant 1 takes sub bit 0 from A1 and sub bit 1 from A0 (offsets 0, 2, 1, 3).
- R5: Variant 2 takes sub bit 0 from A6 and sub bit 1 from A7 (offsets $00, $40, $80, $C0). Variant 3 takes sub bit 0 from A3 and sub bit 1 from A2 (offsets 0, 8, 4, $C).
- R6: Variant 4 takes sub bit 0 from A2 and sub bit 1 from A3 (offsets 0, 4, 8, $C). Variant 5 takes sub bit 0 from A0 and sub bit 1 from A1 (offsets 0, 1, 2, 3).
- R7: Address bits A11-A0 that the chosen variant does not use have no effect on the outputs, so each register is mirrored across its 4 KiB group.
- R8: When `sel_valid` is 1, `sel_onehot` has exactly one bit set, at index (group - 8) * 4 + sub. When `sel_valid` is 0, `sel_onehot` is zero.
- R9: `irq_we[k]` pulses only for a valid select in group $F with sub-index k. The meaning of each bit is k=0 latch low nibble, k=1 latch high nibble, k=2 control, k=3 acknowledge.
- R10: Variant codes 6 and 7 are unsupported and never produce a select.
- R11: While `rst_n` is low, and on the first cycle after it rises with no strobe, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address A15-A0 |
| variant | input | 3 | Static board wiring code, 0 to 5 supported |
| sel_valid | output | 1 | Register select pulse |
| sel_group | output | 4 | Address nibble A15-A12 of the selected register |
| sel_sub | output | 2 | Normalized sub-index |
| sel_onehot | output | 32 | One-hot register select over $8000-$FFFF |
| irq_we | output | 4 | Write strobes for the four $F-group registers |

## Verification
The assertions assume two things about the inputs: `variant` holds steady across a write, and `cpu_addr` and `wr_stb` are driven to known values from reset onward. The bench keeps to this by setting the variant only between bursts and by driving every input on the falling edge. Random addresses cover the whole 16-bit range, so the bench exercises writes below $8000, the mirrored bits and the unsupported variant codes alongside the normal register writes.

// File: rtl/vdec_pkg.sv
package vdec_pkg;
  localparam int ADDR_W    = 16;
  localparam int VAR_W     = 3;
  localparam int SUB_W     = 2;
  localparam int GRP_W     = 4;
  localparam int NUM_GRP   = 8;
  localparam int SUBS      = 1 << SUB_W;
  localparam int NUM_REGS  = NUM_GRP * SUBS;
  localparam int GIDX_W    = $clog2(NUM_GRP);
  localparam logic [GRP_W-1:0] IRQ_GROUP = 4'hF;

  typedef enum logic [VAR_W-1:0] {
    WIRE_A1_A2 = 3'd0,
    WIRE_A1_A0 = 3'd1,
    WIRE_A6_A7 = 3'd2,
    WIRE_A3_A2 = 3'd3,
    WIRE_A2_A3 = 3'd4,
    WIRE_A0_A1 = 3'd5
  } wiring_e;

  typedef logic [SUB_W-1:0] sub_t;
endpackage

// File: rtl/vdec_sub_pick.sv
module vdec_sub_pick
  import vdec_pkg::*;
(
  input  logic [7:0]       addr_lo,
  input  logic [VAR_W-1:0] variant,
  output sub_t             sub,
  output logic             known
);
  always_comb begin
    known = 1'b1;
    sub   = '0;
    case (variant)
      WIRE_A1_A2: sub = {addr_lo[2], addr_lo[1]};
      WIRE_A1_A0: sub = {addr_lo[0], addr_lo[1]};
      WIRE_A6_A7: sub = {addr_lo[7], addr_lo[6]};
      WIRE_A3_A2: sub = {addr_lo[2], addr_lo[3]};
      WIRE_A2_A3: sub = {addr_lo[3], addr_lo[2]};
      WIRE_A0_A1: sub = {addr_lo[1], addr_lo[0]};
      default:    known = 1'b0;
    endcase
  end
endmodule

// File: rtl/vdec_group_decode.sv
module vdec_group_decode
  import vdec_pkg::*;
(
  input  logic [GRP_W-1:0]  nibble,
  input  logic              wr_stb,
  input  logic              known,
  output logic              hit,
  output logic [GIDX_W-1:0] gidx
);
  assign hit  = wr_stb && known && nibble[GRP_W-1];
  assign gidx = nibble[GIDX_W-1:0];
endmodule

// File: rtl/vdec_onehot.sv
module vdec_onehot
  import vdec_pkg::*;
(
  input  logic              en,
  input  logic [GIDX_W-1:0] gidx,
  input  sub_t              sub,
  output logic [NUM_REGS-1:0] onehot
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar s = 0; s < SUBS; s++) begin : g_sub
      assign onehot[g*SUBS+s] = en && (gidx == GIDX_W'(g)) && (sub == SUB_W'(s));
    end
  end
endmodule

// File: rtl/vdec_top.sv
module vdec_top
  import vdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [15:0]       cpu_addr,
  input  logic [2:0]        variant,
  output logic              sel_valid,
  output logic [3:0]        sel_group,
  output logic [1:0]        sel_sub,
  output logic [31:0]       sel_onehot,
  output logic [3:0]        irq_we
);
  sub_t                sub_c;
  logic                known_c, hit_c;
  logic [GIDX_W-1:0]   gidx_c;
  logic [NUM_REGS-1:0] oh_c;

  vdec_sub_pick u_pick (
    .addr_lo (cpu_addr[7:0]),
    .variant (variant),
    .sub     (sub_c),
    .known   (known_c)
  );

  vdec_group_decode u_grp (
    .nibble (cpu_addr[ADDR_W-1 -: GRP_W]),
    .wr_stb (wr_stb),
    .known  (known_c),
    .hit    (hit_c),
    .gidx   (gidx_c)
  );

  vdec_onehot u_oh (
    .en     (hit_c),
    .gidx   (gidx_c),
    .sub    (sub_c),
    .onehot (oh_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_group  <= '0;
      sel_sub    <= '0;
      sel_onehot <= '0;
      irq_we     <= '0;
    end else begin
      sel_valid  <= hit_c;
      sel_group  <= hit_c ? cpu_addr[ADDR_W-1 -: GRP_W] : '0;
      sel_sub    <= hit_c ? sub_c : '0;
      sel_onehot <= oh_c;
      irq_we     <= oh_c[NUM_REGS-1 -: SUBS];
    end
  end

  // R1: low half of the address space never selects
  p_low_addr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !cpu_addr[15]) |=> (!sel_valid && sel_onehot == '0 && irq_we == '0));

  // R2: no strobe, no select
  p_no_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !sel_valid);

  // R3: group follows the address nibble
  p_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> sel_group[3]);

  // R8: one-hot vector agrees with the valid pulse
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_onehot) == (sel_valid ? 1 : 0));

  // R9: interrupt strobes only in the $F group
  p_irq_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_we != '0) |-> (sel_valid && sel_group == IRQ_GROUP && $onehot0(irq_we)));

  // R10: unsupported wiring codes stay silent
  p_bad_variant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (variant > 3'd5) |=> !sel_valid);
endmodule

// File: tb/tb_vdec_top.sv
module tb_vdec_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [2:0]  variant = '0;
  logic        sel_valid;
  logic [3:0]  sel_group;
  logic [1:0]  sel_sub;
  logic [31:0] sel_onehot;
  logic [3:0]  irq_we;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdec_top dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cpu_addr(cpu_addr),
    .variant(variant), .sel_valid(sel_valid), .sel_group(sel_group),
    .sel_sub(sel_sub), .sel_onehot(sel_onehot), .irq_we(irq_we)
  );

  function automatic logic [1:0] ref_sub(input logic [15:0] a, input logic [2:0] v);
    case (v)
      3'd0: return {a[2], a[1]};
      3'd1: return {a[0], a[1]};
      3'd2: return {a[7], a[6]};
      3'd3: return {a[2], a[3]};
      3'd4: return {a[3], a[2]};
      3'd5: return {a[1], a[0]};
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic ref_valid(input logic s, input logic [15:0] a, input logic [2:0] v);
    return s && a[15] && (v <= 3'd5);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check at following negedge (one register stage)
  task automatic do_write(input logic s, input logic [15:0] a, input logic [2:0] v, input string req);
    logic ev;
    logic [1:0] es;
    logic [31:0] eoh;
    logic [3:0] eirq;
    wr_stb = s; cpu_addr = a; variant = v;
    ev = ref_valid(s, a, v);
    es = ev ? ref_sub(a, v) : 2'd0;
    eoh = ev ? (32'd1 << ((int'(a[14:12]) * 4) + int'(es))) : 32'd0;
    eirq = (ev && a[15:12] == 4'hF) ? (4'd1 << es) : 4'd0;
    @(negedge clk);
    check({req, " valid"}, 64'(sel_valid), 64'(ev));
    check({req, " group"}, 64'(sel_group), 64'(ev ? a[15:12] : 4'd0));
    check({req, " sub"}, 64'(sel_sub), 64'(es));
    check({req, " onehot R8"}, 64'(sel_onehot), 64'(eoh));
    check({req, " irq R9"}, 64'(irq_we), 64'(eirq));
    wr_stb = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [15:0] a;
    seed = 1234;
    void'($urandom(seed));
    // R11: reset state, with a strobe pending during reset
    wr_stb = 1'b1; cpu_addr = 16'hF006; variant = 3'd0;
    repeat (3) @(negedge clk);
    check("R11 reset valid", 64'(sel_valid), 64'd0);
    check("R11 reset onehot", 64'(sel_onehot), 64'd0);
    wr_stb = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", 64'({sel_valid, sel_group, sel_sub, sel_onehot, irq_we}), 64'd0);

    // R4 R5 R6: directed offsets per wiring give sub 0..3
    for (int v = 0; v < 6; v++) begin
      logic [15:0] offs [4];
      case (v)
        0: offs = '{16'h0, 16'h2, 16'h4, 16'h6};
        1: offs = '{16'h0, 16'h2, 16'h1, 16'h3};
        2: offs = '{16'h00, 16'h40, 16'h80, 16'hC0};
        3: offs = '{16'h0, 16'h8, 16'h4, 16'hC};
        4: offs = '{16'h0, 16'h4, 16'h8, 16'hC};
        default: offs = '{16'h0, 16'h1, 16'h2, 16'h3};
      endcase
      for (int k = 0; k < 4; k++) begin
        do_write(1'b1, 16'hF000 | offs[k], 3'(v), v < 2 ? "R4" : (v < 4 ? "R5" : "R6"));
        check("R9 irq function order", 64'(sel_sub), 64'(k));
      end
    end
    // R1: low addresses
    do_write(1'b1, 16'h7FFF, 3'd0, "R1 low top");
    do_write(1'b1, 16'h0000, 3'd5, "R1 zero");
    // R2: no strobe
    do_write(1'b0, 16'h9004, 3'd0, "R2 no strobe");
    // R10: unsupported variants
    do_write(1'b1, 16'hF002, 3'd6, "R10 code6");
    do_write(1'b1, 16'h8001, 3'd7, "R10 code7");
    // R7: mirrors
    do_write(1'b1, 16'hBFF9, 3'd0, "R7 mirror v0");
    do_write(1'b1, 16'hC83F, 3'd2, "R7 mirror v2");
    // R3: each group with R8 index
    for (int g = 8; g < 16; g++) do_write(1'b1, 16'(g << 12) | 16'h0A5A, 3'd4, "R3 group sweep");
    // random: R3 R7 R8 across all variants
    for (int n = 0; n < 3000; n++) begin
      a = 16'($urandom);
      do_write(1'($urandom), a, 3'($urandom % 8), "R3 R7 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule